// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This block holds a small bank of binary lock flags that two independent requesters, a left port and a right port, use to agree on who may touch a shared resource. A port asks for a flag by writing 0 to it and gives it up by writing 1. Reading the flag then shows that port whether it won. A flag reads 0 on the side that owns it and 1 on the other side. When both sides read 1, the flag is free. Each flag keeps one request latch per side. A request from the side that does not own the flag is therefore remembered, and that side takes the token in the same cycle the owner lets it go.

Each port has a semaphore select (active low), a memory chip enable that must be high for the flag space to be addressed, an output enable, a read/write strobe, an address, one write data bit and a 16-bit read bus. A read samples the flag on the clock edge that first sees the read, and the port then holds that value for as long as the read stays asserted. This way a change made by the other side cannot alter a value that is being read. The model is fully synchronous to one clock, and an active-low reset frees every flag.

Top module: `sem_token_unit`

## Requirements
- R1: After reset every flag is free: any flag read from either side returns 16'hFFFF.
- R2: A flag is chosen by address bits [2:0] only. Addresses that differ only in bits [12:3] reach the same flag.
- R3: Writing 0 to a free flag gives that side the token. On the next read the owner sees 16'h0000 and the other side sees 16'hFFFF. The other flags are not affected.
- R4: Only the owner can free a flag. When the non-owner writes 1, it only withdraws its own pending request and the owner keeps the token.
- R5: When the non-owner writes 0 to an owned flag, the request is held and is not granted. When the owner then writes 1, the waiting side owns the flag from the next cycle on.
- R6: A flag reads 16'hFFFF on both sides exactly when neither side's request latch holds 0.
- R7: A read drives the flag value onto all 16 data bits. While no read is captured, the read bus is 16'h0000.
- R8: A read captures the flag on the first edge that sees select low, chip enable high, output enable low and the strobe high. The bus keeps that value until select or output enable goes inactive, even if the flag changes in the meantime.
- R9: When both sides write 0 to the same free flag in the same cycle, the left side gets the token and the right side's request is held as pending.
- R10: An access takes effect only when select is low and chip enable is high. Any other combination leaves the flags unchanged and yields no read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, frees all flags |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left memory chip enable, must be high to address flags |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_we_ni | input | 1 | Left strobe: low writes, high reads |
| l_addr_i | input | ADDR_W | Left address, bits [2:0] pick the flag |
| l_wd_i | input | 1 | Left write bit: 0 requests, 1 releases |
| l_rdata_o | output | DATA_W | Left read data, flag replicated |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right memory chip enable, must be high to address flags |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_we_ni | input | 1 | Right strobe: low writes, high reads |
| r_addr_i | input | ADDR_W | Right address, bits [2:0] pick the flag |
| r_wd_i | input | 1 | Right write bit: 0 requests, 1 releases |
| r_rdata_o | output | DATA_W | Right read data, flag replicated |

## Verification
Corrupted owner or request-latch state shows up on the next read of that flag from either side. Both sides read 0 together, both read 1 while a request is pending, or the token fails to move to the waiting side one cycle after the release. A faulty address decode moves a request onto a neighbouring flag, which the next read of that neighbour exposes. The read-hold path is tested by changing the owner while a read is held. A broken capture register shows the new value at once, when it should appear only after the read is reopened.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl #(
  parameter int ADDR_W    = 13,
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sem_ni,
  input  logic                 ce_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wd_i,
  output logic [NUM_FLAGS-1:0] wr_hit_o,
  output logic                 wr_bit_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 rd_start_o,
  output logic                 rd_act_o
);
  logic sel, wr_en, rd_en, rd_q;
  logic addr_hi_unused;

  assign addr_hi_unused = ^addr_i[ADDR_W-1:IDX_W];
  assign idx_o    = addr_i[IDX_W-1:0];
  assign sel      = !sem_ni && ce_ni;
  assign wr_en    = sel && !we_ni;
  assign rd_en    = sel && we_ni && !oe_ni;
  assign wr_bit_o = wd_i;

  always_comb begin
    wr_hit_o = '0;
    if (wr_en) wr_hit_o[idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_en;
  end

  assign rd_start_o = rd_en && !rd_q;
  assign rd_act_o   = rd_q;

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_o |=> rd_act_o); // R8
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_l_i,
  input  logic bit_l_i,
  input  logic wr_r_i,
  input  logic bit_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  logic   req_l_q, req_r_q, req_l_d, req_r_d;
  owner_e owner_q, owner_d;

  // request latches are active low: 0 means this side wants the token
  assign req_l_d = wr_l_i ? bit_l_i : req_l_q;
  assign req_r_d = wr_r_i ? bit_r_i : req_r_q;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (!req_l_d)      owner_d = OWN_LEFT;   // left wins a tie
        else if (!req_r_d) owner_d = OWN_RIGHT;
      end
      OWN_LEFT: begin
        if (req_l_d) owner_d = req_r_d ? OWN_NONE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (req_r_d) owner_d = req_l_d ? OWN_NONE : OWN_LEFT;
      end
      default: owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      owner_q <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);

  AST_FREE_IFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE) == (req_l_q && req_r_q)); // R6
  AST_OWNER_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_q == OWN_LEFT) |-> !req_l_q) and ((owner_q == OWN_RIGHT) |-> !req_r_q)); // R3
  AST_LEFT_NO_STEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && !(wr_l_i && bit_l_i)) |=> owner_q == OWN_LEFT); // R4
  AST_RIGHT_NO_STEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && !(wr_r_i && bit_r_i)) |=> owner_q == OWN_RIGHT); // R4
  AST_HANDOVER_TO_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && wr_l_i && bit_l_i && !wr_r_i && !req_r_q) |=> owner_q == OWN_RIGHT); // R5
  AST_HANDOVER_TO_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && wr_r_i && bit_r_i && !wr_l_i && !req_l_q) |=> owner_q == OWN_LEFT); // R5
  AST_TIE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && wr_l_i && !bit_l_i && wr_r_i && !bit_r_i) |=> owner_q == OWN_LEFT && !req_r_q); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_l_i && !wr_r_i) |=> $stable(owner_q)); // R10
endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  input  logic              rd_act_i,
  input  logic              view_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b1;
    else if (rd_start_i) hold_q <= view_i;
  end

  assign rdata_o = rd_act_i ? {DATA_W{hold_q}} : '0;

  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_i && $past(rd_act_i)) |-> $stable(rdata_o)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act_i |-> rdata_o == '0); // R7
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 16,
  parameter int NUM_FLAGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_ni,
  input  logic              l_ce_ni,
  input  logic              l_oe_ni,
  input  logic              l_we_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wd_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sem_ni,
  input  logic              r_ce_ni,
  input  logic              r_oe_ni,
  input  logic              r_we_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wd_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int IDX_W = $clog2(NUM_FLAGS);
  localparam int SIDES = 2;

  logic [SIDES-1:0]     sem_n, ce_n, oe_n, we_n, wd;
  logic [ADDR_W-1:0]    addr   [SIDES];
  logic [NUM_FLAGS-1:0] wr_hit [SIDES];
  logic [NUM_FLAGS-1:0] own    [SIDES];
  logic [IDX_W-1:0]     idx    [SIDES];
  logic [DATA_W-1:0]    rdata  [SIDES];
  logic [SIDES-1:0]     wr_bit, rd_start, rd_act;
  logic [NUM_FLAGS-1:0] own_l, own_r;

  assign sem_n   = {r_sem_ni, l_sem_ni};
  assign ce_n    = {r_ce_ni, l_ce_ni};
  assign oe_n    = {r_oe_ni, l_oe_ni};
  assign we_n    = {r_we_ni, l_we_ni};
  assign wd      = {r_wd_i, l_wd_i};
  assign addr[0] = l_addr_i;
  assign addr[1] = r_addr_i;
  assign own[0]  = own_l;
  assign own[1]  = own_r;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    sem_port_ctrl #(
      .ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)
    ) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sem_ni(sem_n[s]), .ce_ni(ce_n[s]), .oe_ni(oe_n[s]), .we_ni(we_n[s]),
      .addr_i(addr[s]), .wd_i(wd[s]),
      .wr_hit_o(wr_hit[s]), .wr_bit_o(wr_bit[s]), .idx_o(idx[s]),
      .rd_start_o(rd_start[s]), .rd_act_o(rd_act[s])
    );

    sem_read_hold #(.DATA_W(DATA_W)) u_hold (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .rd_start_i(rd_start[s]), .rd_act_i(rd_act[s]),
      .view_i(~own[s][idx[s]]),
      .rdata_o(rdata[s])
    );
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sem_flag_cell u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_l_i(wr_hit[0][f]), .bit_l_i(wr_bit[0]),
      .wr_r_i(wr_hit[1][f]), .bit_r_i(wr_bit[1]),
      .own_l_o(own_l[f]), .own_r_o(own_r[f])
    );
  end

  assign l_rdata_o = rdata[0];
  assign r_rdata_o = rdata[1];

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0); // R3
endmodule

// File: tb/sem_token_unit_bench.sv
`timescale 1ns/1ps
module sem_token_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        l_sem_n, l_ce_n, l_oe_n, l_we_n, l_wd;
  logic        r_sem_n, r_ce_n, r_oe_n, r_we_n, r_wd;
  logic [12:0] l_addr, r_addr;
  logic [15:0] l_rdata, r_rdata;

  sem_token_unit u_sem_token_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_ni(l_sem_n), .l_ce_ni(l_ce_n), .l_oe_ni(l_oe_n), .l_we_ni(l_we_n),
    .l_addr_i(l_addr), .l_wd_i(l_wd), .l_rdata_o(l_rdata),
    .r_sem_ni(r_sem_n), .r_ce_ni(r_ce_n), .r_oe_ni(r_oe_n), .r_we_ni(r_we_n),
    .r_addr_i(r_addr), .r_wd_i(r_wd), .r_rdata_o(r_rdata)
  );

  typedef struct {
    bit          side;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  function automatic void chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected items and compares with the port being read
  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.side ? r_rdata : l_rdata;
        chk(act === it.exp, it.tag, act, it.exp);
      end
    end
  end

  task automatic set_port(input bit side, input logic sem_n, input logic ce_n,
                          input logic oe_n, input logic we_n,
                          input logic [12:0] a, input logic d);
    if (!side) begin
      l_sem_n = sem_n; l_ce_n = ce_n; l_oe_n = oe_n; l_we_n = we_n; l_addr = a; l_wd = d;
    end else begin
      r_sem_n = sem_n; r_ce_n = ce_n; r_oe_n = oe_n; r_we_n = we_n; r_addr = a; r_wd = d;
    end
  endtask

  task automatic idle(input bit side);
    set_port(side, 1'b1, 1'b1, 1'b1, 1'b1, 13'h0, 1'b1);
  endtask

  task automatic wr_raw(input bit side, input logic [12:0] a, input logic d,
                        input logic sem_n, input logic ce_n);
    set_port(side, sem_n, ce_n, 1'b1, 1'b0, a, d);
    @(negedge clk);
    idle(side);
  endtask

  task automatic wr(input bit side, input logic [12:0] a, input logic d);
    wr_raw(side, a, d, 1'b0, 1'b1);
  endtask

  task automatic wr_pair(input logic [12:0] al, input logic dl,
                         input logic [12:0] ar, input logic dr);
    set_port(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, al, dl);
    set_port(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, ar, dr);
    @(negedge clk);
    idle(1'b0);
    idle(1'b1);
  endtask

  task automatic rd_open(input bit side, input logic [12:0] a);
    set_port(side, 1'b0, 1'b1, 1'b0, 1'b1, a, 1'b1);
    @(negedge clk);
  endtask

  task automatic rd_check(input bit side, input logic [15:0] exp, input string tag);
    item_t it;
    it.side = side; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic rd_close(input bit side);
    idle(side);
    @(negedge clk);
  endtask

  task automatic sem_read(input bit side, input logic [12:0] a,
                          input logic [15:0] exp, input string tag);
    rd_open(side, a);
    rd_check(side, exp, tag);
    rd_close(side);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(1'b0);
    idle(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(l_rdata === 16'h0, "R7 idle left after reset", l_rdata, 16'h0);
    chk(r_rdata === 16'h0, "R7 idle right after reset", r_rdata, 16'h0);

    // R1: all flags free after reset
    for (int f = 0; f < 8; f++) begin
      sem_read(1'b0, 13'(f), 16'hFFFF, $sformatf("R1 left flag %0d free", f));
      sem_read(1'b1, 13'(f), 16'hFFFF, $sformatf("R1 right flag %0d free", f));
    end

    // R3 / R11-style neighbour check
    wr(1'b0, 13'd0, 1'b0);
    sem_read(1'b0, 13'd0, 16'h0000, "R3 left owns flag 0");
    sem_read(1'b1, 13'd0, 16'hFFFF, "R3 right sees flag 0 taken");
    sem_read(1'b0, 13'd1, 16'hFFFF, "R3 neighbour flag 1 untouched");

    // R4: non-owner cannot free
    wr(1'b1, 13'd0, 1'b1);
    sem_read(1'b0, 13'd0, 16'h0000, "R4 right release ignored");
    wr(1'b1, 13'd0, 1'b0);
    sem_read(1'b1, 13'd0, 16'hFFFF, "R5 pending request not granted");
    sem_read(1'b0, 13'd0, 16'h0000, "R4 left keeps token while right waits");

    // R5: handover on release
    wr(1'b0, 13'd0, 1'b1);
    sem_read(1'b1, 13'd0, 16'h0000, "R5 token passed to right");
    sem_read(1'b0, 13'd0, 16'hFFFF, "R5 former owner sees taken");

    // R6: free again
    wr(1'b1, 13'd0, 1'b1);
    sem_read(1'b0, 13'd0, 16'hFFFF, "R6 left sees free");
    sem_read(1'b1, 13'd0, 16'hFFFF, "R6 right sees free");

    // R4: withdrawn pending request
    wr(1'b0, 13'd2, 1'b0);
    wr(1'b1, 13'd2, 1'b0);
    wr(1'b1, 13'd2, 1'b1);
    wr(1'b0, 13'd2, 1'b1);
    sem_read(1'b1, 13'd2, 16'hFFFF, "R4 withdrawn request not granted");
    sem_read(1'b0, 13'd2, 16'hFFFF, "R6 flag 2 free after withdraw");

    // R2: upper address bits ignored
    wr(1'b0, 13'h1FF3, 1'b0);
    sem_read(1'b1, 13'h0003, 16'hFFFF, "R2 right sees alias-taken flag 3");
    sem_read(1'b0, 13'h0AB3, 16'h0000, "R2 left reads own flag via alias");
    wr(1'b0, 13'h0013, 1'b1);
    wr(1'b1, 13'h1E03, 1'b0);
    sem_read(1'b1, 13'h0003, 16'h0000, "R2 right owns flag 3 via alias");
    sem_read(1'b0, 13'h0003, 16'hFFFF, "R2 left sees flag 3 taken");
    wr(1'b1, 13'h0003, 1'b1);

    // R10: gating by select and chip enable
    wr_raw(1'b0, 13'd4, 1'b0, 1'b0, 1'b0);
    sem_read(1'b1, 13'd4, 16'hFFFF, "R10 write with chip enable low ignored");
    sem_read(1'b0, 13'd4, 16'hFFFF, "R10 left not owner after gated write");
    wr_raw(1'b0, 13'd4, 1'b0, 1'b1, 1'b1);
    sem_read(1'b0, 13'd4, 16'hFFFF, "R10 write with select high ignored");
    set_port(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 13'd4, 1'b1);
    @(negedge clk);
    rd_check(1'b0, 16'h0000, "R10 read with chip enable low gives no data");
    rd_close(1'b0);

    // R9: same-cycle tie
    wr_pair(13'd5, 1'b0, 13'd5, 1'b0);
    sem_read(1'b0, 13'd5, 16'h0000, "R9 left wins tie");
    sem_read(1'b1, 13'd5, 16'hFFFF, "R9 right loses tie");
    wr(1'b0, 13'd5, 1'b1);
    sem_read(1'b1, 13'd5, 16'h0000, "R9 losing request kept pending");
    wr(1'b1, 13'd5, 1'b1);
    sem_read(1'b0, 13'd5, 16'hFFFF, "R6 flag 5 free");

    // R8: captured read held through a handover
    wr(1'b0, 13'd6, 1'b0);
    wr(1'b1, 13'd6, 1'b0);
    rd_open(1'b1, 13'd6);
    rd_check(1'b1, 16'hFFFF, "R8 read captured");
    wr(1'b0, 13'd6, 1'b1);
    rd_check(1'b1, 16'hFFFF, "R8 held value unchanged by handover");
    rd_close(1'b1);
    chk(r_rdata === 16'h0, "R7 bus zero after read closes", r_rdata, 16'h0);
    sem_read(1'b1, 13'd6, 16'h0000, "R8 reopened read sees new owner");
    wr(1'b1, 13'd6, 1'b1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule